// File: doc/BRIEF.md
# Two-Wire Register-Array Slave with Write Unlock and Internal Write Cycle

This block is the serial front end of a small clock/control register array. It watches an already synchronized two-wire bus (SCL and SDA) and pulls SDA low through an open-drain enable. It recognises one fixed device byte. It takes a 16-bit word address sent as two bytes and can do three things: commit a single data byte, return bytes starting from its internal pointer, or return bytes starting from a freshly loaded address (a dummy write followed by a repeated start). The register storage sits outside the block. The block reaches it through a one-cycle write strobe and a combinational read port.

Writes are guarded. A status register at the top address always accepts a write. Every other location only accepts a write after two earlier, separate transactions have written 02h and then 06h to the status register. Each committed or refused write transaction ends with a stop, which starts a fixed-length internal write cycle. While that cycle runs, the block ignores the bus completely and keeps SDA released.

Top module: `rtcRegSlave`

## Requirements
- R1: The block acknowledges only a device byte whose bits 7..1 are 1101111 (bit 0 is the direction: 1 = read, 0 = write). Any other device byte is not acknowledged, and SDA stays released until the next start.
- R2: After a write-direction device byte, the block receives the word address high byte first and then the low byte. The high byte is always acknowledged. The low byte is not acknowledged when the 16-bit address is 40h or above; in that case the pointer is left unchanged.
- R3: After reset, SDA is released, busy is low and the pointer is 00h, so a read issued straight away returns location 00h.
- R4: The block drives an acknowledge (SDA low during the ninth clock) after an accepted device byte, after both address bytes and after a write data byte. SDA enable changes only while SCL is low.
- R5: Read data leaves MSB first. The pointer advances after every byte sent and wraps from 3Fh to 00h. A master not-acknowledge ends the burst, and SDA then stays released until the next start or stop.
- R6: A stop that follows an acknowledged data byte commits the byte with a single-cycle regWe pulse carrying the pointer address and the data. A write to address 3Fh (status) always commits.
- R7: A write to any address other than 3Fh commits only if the two most recent status writes, in separate transactions, were 02h and then 06h. A status write of any other value, including 06h that does not follow 02h, locks the array again.
- R8: A stop after a write data byte starts a busy period of exactly BUSY_CYCLES clocks. During that period busy is high, every bus event is ignored and SDA is released.
- R9: A stop or a start that arrives before the data byte is complete aborts the transaction: no regWe and no busy period.
- R10: A random read, made of a write-direction device byte, two address bytes, a repeated start and a read-direction device byte, returns data starting at the loaded address.
- R11: After every write transaction ends with a stop, committed or refused, the pointer holds the written address plus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Synchronized SCL level |
| sdaIn | input | 1 | Synchronized SDA level |
| sdaOe | output | 1 | 1 pulls SDA low |
| busy | output | 1 | Internal write cycle in progress |
| regWe | output | 1 | One-cycle write strobe to the register array |
| regWrAddr | output | ADDR_W | Write address |
| regWrData | output | 8 | Write data |
| regRdAddr | output | ADDR_W | Read address (current pointer) |
| regRdData | input | 8 | Read data returned combinationally for regRdAddr |

## Verification
The bench keeps the default 64-byte array (ADDR_W = 6), so the status location and the 3Fh-to-00h pointer wrap are both reached by a short burst. BUSY_CYCLES is raised to 400. That makes the internal write cycle long enough to hold a complete start, device byte and stop, so the test can show that a whole transaction during the busy period gets no acknowledge. The busy length is measured against that value.

// File: rtl/rtcSlavePkg.sv
package rtcSlavePkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_WDONE, ST_TX, ST_MACK, ST_WAIT, ST_BUSY
  } ctrlStateT;

  typedef enum logic [1:0] {
    FLD_SLAVE, FLD_WAHI, FLD_WALO, FLD_DATA
  } fieldT;

  // control -> datapath strobes
  typedef struct packed {
    logic clrBits;
    logic bitInc;
    logic rxShift;
    logic saveHi;
    logic loadPtr;
    logic incPtr;
    logic loadTx;
    logic txShift;
    logic grabAck;
    logic commit;
    logic ackOut;
    logic txEn;
  } strobeT;

  // datapath -> control events and flags
  typedef struct packed {
    logic       sclRise;
    logic       sclFall;
    logic       startSeen;
    logic       stopSeen;
    logic       byteFull;
    logic [7:0] rxByte;
    logic       addrOk;
    logic       busyDone;
    logic       masterAck;
  } eventT;

endpackage

// File: rtl/rtcSlaveCtrl.sv
module rtcSlaveCtrl
  import rtcSlavePkg::*;
#(
  parameter logic [6:0] DEV_ID = 7'h6F
) (
  input  logic   clk,
  input  logic   rstN,
  input  eventT  ev,
  output strobeT stb,
  output logic   busy
);

  ctrlStateT state, stateNxt;
  fieldT     field, fieldNxt;
  logic      ackOn, ackOnNxt;
  logic      isRead, isReadNxt;

  always_comb begin
    stb       = '0;
    stateNxt  = state;
    fieldNxt  = field;
    ackOnNxt  = ackOn;
    isReadNxt = isRead;
    stb.ackOut = (state == ST_ACK) && ackOn;
    stb.txEn   = (state == ST_TX);

    if (state == ST_BUSY) begin
      // deaf to the bus until the write cycle ends
      if (ev.busyDone) stateNxt = ST_IDLE;
    end else if (ev.stopSeen) begin
      if (state == ST_WDONE) begin
        stb.commit = 1'b1;
        stateNxt   = ST_BUSY;
      end else begin
        stateNxt = ST_IDLE;
      end
    end else if (ev.startSeen) begin
      stateNxt    = ST_RX;
      fieldNxt    = FLD_SLAVE;
      stb.clrBits = 1'b1;
    end else begin
      case (state)
        ST_RX: begin
          if (ev.sclRise && !ev.byteFull) begin
            stb.rxShift = 1'b1;
            stb.bitInc  = 1'b1;
          end
          if (ev.sclFall && ev.byteFull) begin
            stateNxt = ST_ACK;
            case (field)
              FLD_SLAVE: begin
                ackOnNxt  = (ev.rxByte[7:1] == DEV_ID);
                isReadNxt = ev.rxByte[0];
              end
              FLD_WAHI: begin
                ackOnNxt   = 1'b1;
                stb.saveHi = 1'b1;
              end
              FLD_WALO: begin
                ackOnNxt    = ev.addrOk;
                stb.loadPtr = ev.addrOk;
              end
              default: ackOnNxt = 1'b1;
            endcase
          end
        end
        ST_ACK: begin
          if (ev.sclFall) begin
            stb.clrBits = 1'b1;
            if (!ackOn) begin
              stateNxt = ST_WAIT;
            end else begin
              case (field)
                FLD_SLAVE: begin
                  if (isRead) begin
                    stb.loadTx = 1'b1;
                    stateNxt   = ST_TX;
                  end else begin
                    fieldNxt = FLD_WAHI;
                    stateNxt = ST_RX;
                  end
                end
                FLD_WAHI: begin
                  fieldNxt = FLD_WALO;
                  stateNxt = ST_RX;
                end
                FLD_WALO: begin
                  fieldNxt = FLD_DATA;
                  stateNxt = ST_RX;
                end
                default: stateNxt = ST_WDONE;
              endcase
            end
          end
        end
        ST_TX: begin
          if (ev.sclRise && !ev.byteFull) stb.bitInc = 1'b1;
          if (ev.sclFall) begin
            if (ev.byteFull) begin
              stb.incPtr = 1'b1;
              stateNxt   = ST_MACK;
            end else begin
              stb.txShift = 1'b1;
            end
          end
        end
        ST_MACK: begin
          if (ev.sclRise) stb.grabAck = 1'b1;
          if (ev.sclFall) begin
            if (ev.masterAck) begin
              stb.loadTx  = 1'b1;
              stb.clrBits = 1'b1;
              stateNxt    = ST_TX;
            end else begin
              stateNxt = ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      field  <= FLD_SLAVE;
      ackOn  <= 1'b0;
      isRead <= 1'b0;
    end else begin
      state  <= stateNxt;
      field  <= fieldNxt;
      ackOn  <= ackOnNxt;
      isRead <= isReadNxt;
    end
  end

  assign busy = (state == ST_BUSY);

endmodule

// File: rtl/rtcSlaveDatapath.sv
module rtcSlaveDatapath
  import rtcSlavePkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int BUSY_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  strobeT            stb,
  output eventT             ev,
  output logic              sdaOe,
  output logic              regWe,
  output logic [ADDR_W-1:0] regWrAddr,
  output logic [7:0]        regWrData,
  output logic [ADDR_W-1:0] regRdAddr,
  input  logic [7:0]        regRdData
);

  localparam logic [ADDR_W-1:0] STATUS_ADDR = '1;
  localparam int                CNT_W       = $clog2(BUSY_CYCLES + 1);
  localparam logic [CNT_W-1:0]  BUSY_LOAD   = CNT_W'(BUSY_CYCLES - 1);
  localparam logic [7:0]        UNLOCK_A    = 8'h02;
  localparam logic [7:0]        UNLOCK_B    = 8'h06;

  typedef enum logic [1:0] {LK_LOCKED, LK_HALF, LK_OPEN} lockT;

  logic              sclQ, sdaQ;
  logic [3:0]        bitCnt;
  logic [7:0]        rxReg, txReg, waHi;
  logic [ADDR_W-1:0] ptr;
  lockT              lock;
  logic [CNT_W-1:0]  busyCnt;
  logic              masterAckQ;
  logic              atStatus;

  assign atStatus = (ptr == STATUS_ADDR);

  always_comb begin
    ev.sclRise   = sclIn & ~sclQ;
    ev.sclFall   = ~sclIn & sclQ;
    ev.startSeen = sclIn & sclQ & sdaQ & ~sdaIn;
    ev.stopSeen  = sclIn & sclQ & ~sdaQ & sdaIn;
    ev.byteFull  = (bitCnt == 4'd8);
    ev.rxByte    = rxReg;
    ev.addrOk    = (waHi == 8'd0) && ((rxReg >> ADDR_W) == 8'd0);
    ev.busyDone  = (busyCnt == '0);
    ev.masterAck = masterAckQ;
  end

  assign sdaOe     = stb.ackOut | (stb.txEn & ~txReg[7]);
  assign regRdAddr = ptr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ       <= 1'b1;
      sdaQ       <= 1'b1;
      bitCnt     <= '0;
      rxReg      <= '0;
      txReg      <= '0;
      waHi       <= '0;
      ptr        <= '0;
      lock       <= LK_LOCKED;
      busyCnt    <= '0;
      masterAckQ <= 1'b0;
      regWe      <= 1'b0;
      regWrAddr  <= '0;
      regWrData  <= '0;
    end else begin
      sclQ  <= sclIn;
      sdaQ  <= sdaIn;
      regWe <= 1'b0;

      if (stb.clrBits)     bitCnt <= '0;
      else if (stb.bitInc) bitCnt <= bitCnt + 4'd1;

      if (stb.rxShift) rxReg <= {rxReg[6:0], sdaIn};
      if (stb.saveHi)  waHi  <= rxReg;

      if (stb.loadTx)       txReg <= regRdData;
      else if (stb.txShift) txReg <= {txReg[6:0], 1'b0};

      if (stb.grabAck) masterAckQ <= ~sdaIn;

      if (stb.loadPtr)                    ptr <= rxReg[ADDR_W-1:0];
      else if (stb.incPtr || stb.commit) ptr <= ptr + 1'b1;

      if (stb.commit) begin
        regWe     <= atStatus || (lock == LK_OPEN);
        regWrAddr <= ptr;
        regWrData <= rxReg;
        if (atStatus) begin
          if (rxReg == UNLOCK_A)                          lock <= LK_HALF;
          else if (rxReg == UNLOCK_B && lock == LK_HALF)  lock <= LK_OPEN;
          else                                            lock <= LK_LOCKED;
        end
      end

      if (stb.commit)           busyCnt <= BUSY_LOAD;
      else if (busyCnt != '0)   busyCnt <= busyCnt - 1'b1;
    end
  end

endmodule

// File: rtl/rtcRegSlave.sv
module rtcRegSlave
  import rtcSlavePkg::*;
#(
  parameter int         ADDR_W      = 6,
  parameter int         BUSY_CYCLES = 64,
  parameter logic [6:0] DEV_ID      = 7'h6F
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOe,
  output logic              busy,
  output logic              regWe,
  output logic [ADDR_W-1:0] regWrAddr,
  output logic [7:0]        regWrData,
  output logic [ADDR_W-1:0] regRdAddr,
  input  logic [7:0]        regRdData
);

  strobeT stb;
  eventT  ev;

  rtcSlaveCtrl #(.DEV_ID(DEV_ID)) uCtrl (
    .clk  (clk),
    .rstN (rstN),
    .ev   (ev),
    .stb  (stb),
    .busy (busy)
  );

  rtcSlaveDatapath #(.ADDR_W(ADDR_W), .BUSY_CYCLES(BUSY_CYCLES)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .sclIn     (sclIn),
    .sdaIn     (sdaIn),
    .stb       (stb),
    .ev        (ev),
    .sdaOe     (sdaOe),
    .regWe     (regWe),
    .regWrAddr (regWrAddr),
    .regWrData (regWrData),
    .regRdAddr (regRdAddr),
    .regRdData (regRdData)
  );

endmodule

// File: rtl/rtcRegSlaveChk.sv
module rtcRegSlaveChk #(
  parameter int BUSY_CYCLES = 64
) (
  input logic clk,
  input logic rstN,
  input logic sclIn,
  input logic sdaOe,
  input logic busy,
  input logic regWe
);

  logic [31:0] runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     runLen <= '0;
    else if (busy) runLen <= runLen + 32'd1;
    else           runLen <= '0;
  end

  AST_BUSY_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !sdaOe); // R8

  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (runLen == 32'(BUSY_CYCLES))); // R8

  AST_WE_IN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    regWe |-> busy); // R6

  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    regWe |=> !regWe); // R6

  AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(sdaOe) || $fell(sdaOe)) |-> !sclIn); // R4

endmodule

bind rtcRegSlave rtcRegSlaveChk #(.BUSY_CYCLES(BUSY_CYCLES)) uChk (
  .clk   (clk),
  .rstN  (rstN),
  .sclIn (sclIn),
  .sdaOe (sdaOe),
  .busy  (busy),
  .regWe (regWe)
);

// File: tb/rtcRegSlave_test.sv
`timescale 1ns/1ps
module rtcRegSlave_test;

  localparam int BUSY_N = 400;
  localparam logic [7:0] DEV_W = 8'hDE;
  localparam logic [7:0] DEV_R = 8'hDF;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sclM = 1'b1;
  logic       sdaM = 1'b1;
  logic       sdaOe, busy, regWe;
  logic [5:0] regWrAddr, regRdAddr;
  logic [7:0] regWrData, regRdData;
  wire        sdaLine = sdaM & ~sdaOe;

  int nChecks = 0;
  int nFail   = 0;
  int weCount = 0;
  int busyRun = 0;
  int lastRun = 0;
  logic busyDrive = 1'b0;

  logic [7:0] mem   [64];
  logic [7:0] model [64];

  always #2.5 clk = ~clk;

  rtcRegSlave #(.ADDR_W(6), .BUSY_CYCLES(BUSY_N)) uut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .busy(busy), .regWe(regWe), .regWrAddr(regWrAddr), .regWrData(regWrData),
    .regRdAddr(regRdAddr), .regRdData(regRdData)
  );

  assign regRdData = mem[regRdAddr];

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 64; i++) mem[i] <= 8'(i * 7 + 3);
    end else if (regWe) begin
      mem[regWrAddr] <= regWrData;
    end
  end

  always @(posedge clk) begin
    if (rstN && regWe) weCount <= weCount + 1;
    if (busy && sdaOe) busyDrive <= 1'b1;
    if (busy) busyRun <= busyRun + 1;
    else begin
      if (busyRun != 0) lastRun <= busyRun;
      busyRun <= 0;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold();
    repeat (4) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; hold();
    sclM = 1'b1; hold();
    sdaM = 1'b0; hold();
    sclM = 1'b0; hold();
  endtask

  task automatic busStop();
    sdaM = 1'b0; hold();
    sclM = 1'b1; hold();
    sdaM = 1'b1; hold();
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sdaM = b[i]; hold();
      sclM = 1'b1; hold();
      sclM = 1'b0; hold();
    end
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    sendBits(b, 8);
    sdaM = 1'b1; hold();
    sclM = 1'b1; hold();
    ack = ~sdaLine;
    sclM = 1'b0; hold();
  endtask

  task automatic readByte(input logic giveAck, output logic [7:0] v);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hold();
      sclM = 1'b1; hold();
      v[i] = sdaLine;
      sclM = 1'b0;
    end
    sdaM = ~giveAck; hold();
    sclM = 1'b1; hold();
    sclM = 1'b0; hold();
    sdaM = 1'b1; hold();
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (busy) @(negedge clk);
    hold();
  endtask

  // R4 R6: full write transaction, every byte must be acknowledged
  task automatic writeReg(input logic [7:0] lo, input logic [7:0] d, input bit waitDone);
    logic a;
    busStart();
    sendByte(DEV_W, a); check("R4 device byte ack", a, 1);
    sendByte(8'h00, a); check("R4 addr hi ack", a, 1);
    sendByte(lo, a);    check("R4 addr lo ack", a, 1);
    sendByte(d, a);     check("R4 data ack", a, 1);
    busStop();
    if (waitDone) waitIdle();
  endtask

  // R10 R5: random read of n bytes from lo, compared with the model
  task automatic randRead(input string req, input logic [7:0] lo, input int n);
    logic a;
    logic [7:0] v;
    busStart();
    sendByte(DEV_W, a);
    sendByte(8'h00, a);
    sendByte(lo, a);
    busStart();
    sendByte(DEV_R, a); check({req, " read ack"}, a, 1);
    for (int i = 0; i < n; i++) begin
      readByte(i < n - 1, v);
      check(req, v, model[(lo + i) % 64]);
    end
    busStop();
  endtask

  task automatic curRead(input string req, input logic [7:0] exp);
    logic a;
    logic [7:0] v;
    busStart();
    sendByte(DEV_R, a); check("R1 read device ack", a, 1);
    readByte(1'b0, v);
    check(req, v, exp);
    busStop();
  endtask

  task automatic testReset();
    check("R3 sdaOe after reset", sdaOe, 0);
    check("R3 busy after reset", busy, 0);
    check("R3 pointer after reset", regRdAddr, 0);
    curRead("R3 first current read", model[0]);
  endtask

  task automatic testBadDevice();
    logic a;
    int w0 = weCount;
    busStart();
    sendByte(8'hA0, a); check("R1 foreign device nack", a, 0);
    sendByte(8'h00, a); check("R1 stays off bus", a, 0);
    busStop();
    busStart();
    sendByte(8'hDC, a); check("R1 near-miss device nack", a, 0);
    busStop();
    check("R1 no write", weCount, w0);
  endtask

  task automatic testLocked();
    int w0 = weCount;
    writeReg(8'h05, 8'h77, 1'b1);
    check("R7 locked write refused", weCount, w0);
    check("R8 busy length", lastRun, BUSY_N);
    curRead("R11 pointer after write", model[6]);
    randRead("R7 locked location kept", 8'h05, 1);
  endtask

  task automatic testUnlock();
    int w0 = weCount;
    writeReg(8'h3F, 8'h02, 1'b1); model[63] = 8'h02;
    check("R6 status write commits", weCount, w0 + 1);
    writeReg(8'h3F, 8'h06, 1'b1); model[63] = 8'h06;
    writeReg(8'h05, 8'h77, 1'b1); model[5] = 8'h77;
    check("R7 unlocked write commits", weCount, w0 + 3);
    randRead("R10 random read after unlock", 8'h05, 1);
    randRead("R6 status readback", 8'h3F, 1);
  endtask

  task automatic testRelock();
    int w0 = weCount;
    writeReg(8'h3F, 8'h09, 1'b1); model[63] = 8'h09;
    writeReg(8'h05, 8'h11, 1'b1);
    check("R7 relock by other value", weCount, w0 + 1);
    writeReg(8'h3F, 8'h06, 1'b1); model[63] = 8'h06;
    writeReg(8'h07, 8'h33, 1'b1);
    check("R7 06h alone does not unlock", weCount, w0 + 2);
    randRead("R7 relocked data kept", 8'h05, 1);
    randRead("R7 data at 07 kept", 8'h07, 1);
  endtask

  task automatic testRange();
    logic a;
    busStart();
    sendByte(DEV_W, a);
    sendByte(8'h00, a);
    sendByte(8'h40, a); check("R2 low byte 40h nack", a, 0);
    busStop();
    busStart();
    sendByte(DEV_W, a);
    sendByte(8'h01, a); check("R2 high byte always ack", a, 1);
    sendByte(8'h00, a); check("R2 address 0100h nack", a, 0);
    busStop();
  endtask

  task automatic testWrap();
    randRead("R5 burst wraps 3Fh to 00h", 8'h3E, 3);
  endtask

  task automatic testBusyDeaf();
    logic a;
    writeReg(8'h3F, 8'h02, 1'b1); model[63] = 8'h02;
    writeReg(8'h3F, 8'h06, 1'b1); model[63] = 8'h06;
    busyDrive = 1'b0;
    writeReg(8'h09, 8'h5A, 1'b0); model[9] = 8'h5A;
    busStart();
    sendByte(DEV_W, a); check("R8 no ack while busy", a, 0);
    busStop();
    check("R8 still busy after ignored transfer", busy, 1);
    waitIdle();
    check("R8 SDA released in busy", busyDrive, 0);
    randRead("R6 committed data", 8'h09, 1);
  endtask

  task automatic testAbort();
    logic a;
    int w0 = weCount;
    busStart();
    sendByte(DEV_W, a);
    sendByte(8'h00, a);
    sendByte(8'h0A, a);
    sendBits(8'hC3, 4);
    busStop();
    hold();
    check("R9 stop mid-byte no busy", busy, 0);
    busStart();
    sendByte(DEV_W, a);
    sendByte(8'h00, a);
    sendByte(8'h0B, a);
    sendBits(8'h3C, 3);
    busStart();
    busStop();
    hold();
    check("R9 start mid-byte no busy", busy, 0);
    check("R9 no write after aborts", weCount, w0);
    randRead("R9 location 0A kept", 8'h0A, 2);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) model[i] = 8'(i * 7 + 3);
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    hold();
    testReset();
    testBadDevice();
    testLocked();
    testUnlock();
    testRelock();
    testRange();
    testWrap();
    testBusyDeaf();
    testAbort();
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

endmodule